// File: doc/BRIEF.md
# Byte-Strobe SRAM Bus Controller

This block sits between an internal requester and an external static RAM that has one select strobe per byte lane. A requester presents an address, a read or write flag, byte enables and write data. It may also ask for a full 32-byte line transfer. The controller then runs the external bus cycles. It drives the chip select, the read strobe, the direction line, the address and the per-lane strobes, and it drives or samples the shared data bus.

The per-lane strobes are active low and work in both directions. During a write they mark the lanes being stored. During a read they act as byte selects, so the memory drives only the lanes that were asked for. A strobe goes active at the falling edge inside the first access cycle and goes inactive at the rising edge that ends the access. The read strobe is released at that same rising edge.

Line transfers start at the beat that holds the requested address. They then step by the bus width and wrap inside the aligned 32-byte block. The chip select stays active for the whole line. The external bus can be set to 16 or 32 bits wide. Setting the multiplexed-bus flag turns off the byte-select use of the strobes on reads.

Top module: `bytesel_sram_ctrl`

## Requirements
- R1: While reset is held and directly after it, chip select, read strobe and all four lane strobes are high (inactive), the direction line is high (read), and busy, done and rd_valid are low.
- R2: A single 32-bit-bus write asserts exactly the lanes in req_be (bit i selects data bits 8i+7..8i), with the direction line low and the read strobe high.
- R3: Every lane strobe stays high for the whole setup cycle and for the first half of the first access cycle. It falls at the falling edge of that cycle and rises at the rising edge that ends the last access cycle of the beat.
- R4: A read asserts the read strobe during the access cycles and asserts only the requested lanes. All other lane strobes stay high.
- R5: Each beat takes one setup cycle followed by WAIT_CYC+1 access cycles. Read data is sampled at the rising edge that ends the last access cycle, and it is presented on rd_data with a one-cycle rd_valid pulse in the next cycle. Lanes that were not read return zero.
- R6: With cfg_wide=0 (16-bit bus), at most lanes 0 and 1 are used. we_n[3:2] stay high, beats are 2 bytes, and rd_data[31:16] is zero.
- R7: A line transfer (req_burst=1) runs 32/width beats. Beat k uses the address (aligned start offset + k*width) mod 32 inside the 32-byte block of the request. The start offset is the request address rounded down to the bus width.
- R8: From acceptance until the last beat completes, chip select stays low and busy stays high. A request presented during that time is not taken.
- R9: With cfg_mpx=1, reads assert no lane strobe, while writes assert their lanes as usual.
- R10: done pulses for one cycle in the cycle after the last access cycle, and chip select is already high in that cycle.
- R11: Single writes place req_wdata byte i on lane i. In a line write, the beat at block offset o drives req_wdata bytes o and up, so line byte n is stored at block offset n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 32-bit external bus, 0: 16-bit |
| cfg_mpx | input | 1 | Multiplexed-bus mode set for this region; disables read byte selects |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1: write, 0: read |
| req_burst | input | 1 | 1: 32-byte wrapped line transfer |
| req_addr | input | AW | Byte address of the request |
| req_be | input | 4 | Byte enables for single accesses |
| req_wdata | input | 256 | Write data; low 32 bits for single writes, whole line for line writes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| rd_valid | output | 1 | One-cycle pulse per read beat |
| rd_data | output | 32 | Read data of the beat just completed |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rnw | output | 1 | Direction: 1 read, 0 write |
| bus_addr | output | AW | External byte address of the current beat |
| bus_we_n | output | 4 | Per-lane strobes, active low |
| bus_dq | inout | 32 | Shared data bus |

## Verification
The hardest case to reach from the ports is a request that arrives while a line transfer is still running. To reach it, the bench starts a wrapped line read and then, without dropping req_valid, switches the request fields to a write at another block for the whole burst. Chip select, direction and the block address must stay unchanged, and afterwards no byte of memory may have changed. The half-cycle strobe edges are observed by sampling the bus both before and after each falling edge. A byte-level memory model behind the bus compares the lanes actually stored and driven against an independent shadow copy.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int LINE_BYTES = 32;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int DQ_W       = 32;
    localparam int LANES      = DQ_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ACC   = 2'd2
    } st_e;

    // lanes in use for the selected bus width
    function automatic logic [LANES-1:0] width_mask(input logic wide);
        return wide ? 4'hF : 4'h3;
    endfunction

    // offset inside the line, rounded down to the bus width
    function automatic logic [OFF_W-1:0] align_off(input logic [OFF_W-1:0] a,
                                                    input logic wide);
        return wide ? {a[OFF_W-1:2], 2'b00} : {a[OFF_W-1:1], 1'b0};
    endfunction

    // offset of beat k, wrapping inside the line
    function automatic logic [OFF_W-1:0] beat_off(input logic [OFF_W-1:0] start,
                                                   input logic [3:0] beat,
                                                   input logic wide);
        logic [OFF_W-1:0] step;
        step = wide ? {beat[2:0], 2'b00} : {beat, 1'b0};
        return start + step;
    endfunction

    function automatic logic [DQ_W-1:0] line_slice(input logic [LINE_W-1:0] line,
                                                    input logic [OFF_W-1:0] off);
        logic [LINE_W-1:0] sh;
        sh = line >> {off, 3'b000};
        return sh[DQ_W-1:0];
    endfunction

endpackage

// File: rtl/bsc_seq.sv
module bsc_seq
    import bsc_pkg::*;
#(
    parameter int WAIT_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       burst,
    input  logic       wide,
    output st_e        st,
    output logic [3:0] beat,
    output logic       last_acc,
    output logic       done
);
    localparam int WCW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

    logic [WCW-1:0] wcnt;
    logic [3:0]     last_beat;

    assign last_beat = !burst ? 4'd0 : (wide ? 4'd7 : 4'd15);
    assign last_acc  = (st == ST_ACC) && (wcnt == WCW'(WAIT_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            beat <= '0;
            wcnt <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_SETUP;
                        beat <= '0;
                    end
                end
                ST_SETUP: begin
                    st   <= ST_ACC;
                    wcnt <= '0;
                end
                ST_ACC: begin
                    if (last_acc) begin
                        if (beat == last_beat) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            beat <= beat + 4'd1;
                            st   <= ST_SETUP;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: a setup cycle is always followed by an access cycle
    p_setup_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP) |=> (st == ST_ACC));

    // R7: beat counter never passes the line length
    p_beat_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |-> (beat <= last_beat));

endmodule

// File: rtl/bsc_addr.sv
module bsc_addr
    import bsc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-OFF_W-1:0] base,
    input  logic [OFF_W-1:0]    start,
    input  logic [3:0]          beat,
    input  logic                wide,
    input  logic                active,
    output logic [OFF_W-1:0]    off,
    output logic [AW-1:0]       addr
);
    assign off  = beat_off(start, beat, wide);
    assign addr = active ? {base, off} : '0;
endmodule

// File: rtl/bsc_strobe.sv
module bsc_strobe
    import bsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [LANES-1:0] smask,
    output logic [LANES-1:0] we_n
);
    // access phase seen at the falling edge: opens the strobe half a cycle late
    logic acc_fall;

    always_ff @(negedge clk) begin
        if (rst) acc_fall <= 1'b0;
        else     acc_fall <= acc;
    end

    // released as soon as the rising edge ends the access phase
    assign we_n = ~(smask & {LANES{acc & acc_fall}});

    // R3: strobes still high in the first half of the first access cycle
    p_fall_late_r3: assert property (@(negedge clk) disable iff (rst)
        $rose(acc) |-> (&we_n));

    // R3: after the access phase ends, the strobes are high again
    p_rise_off_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(acc) |-> (&we_n));

endmodule

// File: rtl/bytesel_sram_ctrl.sv
module bytesel_sram_ctrl
    import bsc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wide,
    input  logic                cfg_mpx,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_burst,
    input  logic [AW-1:0]       req_addr,
    input  logic [3:0]          req_be,
    input  logic [255:0]        req_wdata,
    output logic                busy,
    output logic                done,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic                bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_rnw,
    output logic [AW-1:0]       bus_addr,
    output logic [3:0]          bus_we_n,
    inout  wire  [31:0]         bus_dq
);
    localparam int BASE_W = AW - OFF_W;

    st_e               st;
    logic [3:0]        beat;
    logic              last_acc;
    logic              accept;
    logic              wr_q, burst_q, wide_q, mpx_q;
    logic [LANES-1:0]  dmask_q, smask_q, wmask, req_mask;
    logic [BASE_W-1:0] base_q;
    logic [OFF_W-1:0]  start_q, off;
    logic [LINE_W-1:0] line_q;
    logic [DQ_W-1:0]   wdrv_q;

    assign accept   = (st == ST_IDLE) && req_valid;
    assign wmask    = width_mask(cfg_wide);
    assign req_mask = req_burst ? wmask : (req_be & wmask);

    bsc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .burst    (burst_q),
        .wide     (wide_q),
        .st       (st),
        .beat     (beat),
        .last_acc (last_acc),
        .done     (done)
    );

    bsc_addr #(.AW(AW)) u_addr (
        .base   (base_q),
        .start  (start_q),
        .beat   (beat),
        .wide   (wide_q),
        .active (busy),
        .off    (off),
        .addr   (bus_addr)
    );

    bsc_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .acc   (st == ST_ACC),
        .smask (smask_q),
        .we_n  (bus_we_n)
    );

    // transaction context, captured once at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            burst_q <= 1'b0;
            wide_q  <= 1'b1;
            mpx_q   <= 1'b0;
            dmask_q <= '0;
            smask_q <= '0;
            base_q  <= '0;
            start_q <= '0;
            line_q  <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            burst_q <= req_burst;
            wide_q  <= cfg_wide;
            mpx_q   <= cfg_mpx;
            dmask_q <= req_mask;
            smask_q <= (!req_write && cfg_mpx) ? '0 : req_mask;
            base_q  <= req_addr[AW-1:OFF_W];
            start_q <= align_off(req_addr[OFF_W-1:0], cfg_wide);
            line_q  <= req_wdata;
        end
    end

    // write data for the coming access phase
    always_ff @(posedge clk) begin
        if (rst)                 wdrv_q <= '0;
        else if (st == ST_SETUP) wdrv_q <= burst_q ? line_slice(line_q, off)
                                                   : line_q[DQ_W-1:0];
    end

    // read capture at the end of the last access cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= last_acc && !wr_q;
            if (last_acc && !wr_q) begin
                for (int i = 0; i < LANES; i++)
                    rd_data[8*i +: 8] <= dmask_q[i] ? bus_dq[8*i +: 8] : 8'h00;
            end
        end
    end

    assign busy     = (st != ST_IDLE);
    assign bus_cs_n = (st == ST_IDLE);
    assign bus_rd_n = !((st == ST_ACC) && !wr_q);
    assign bus_rnw  = !(busy && wr_q);
    assign bus_dq   = (busy && wr_q) ? wdrv_q : 'z;

    // R7: the block part of the address is frozen while chip select is held
    p_addr_block_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && $past(!bus_cs_n)) |->
            (bus_addr[AW-1:OFF_W] == $past(bus_addr[AW-1:OFF_W])));

    // R6: upper lanes idle on a 16-bit bus
    p_narrow_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !wide_q) |-> (bus_we_n[3:2] == 2'b11));

    // R9: multiplexed mode keeps read byte selects off
    p_mpx_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && mpx_q && !wr_q) |-> (&bus_we_n));

    // R10: done only once chip select has been dropped
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_cs_n);

    // R5: read data valid follows an access cycle of a read
    p_rdv_src_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(st) == ST_ACC && !$past(wr_q)));

endmodule

// File: tb/bytesel_sram_ctrl_test.sv
module bytesel_sram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int WAIT       = 1;

    typedef struct packed {
        logic       wr;
        logic       burst;
        logic       wide;
        logic       mpx;
        logic [5:0] addr;
        logic [3:0] be;
        logic [3:0] lanes;
        logic [4:0] beats;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 6'h04, 4'hF, 4'hF, 5'd1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 6'h08, 4'hF, 4'hF, 5'd8},
        '{1'b0, 1'b0, 1'b1, 1'b0, 6'h0C, 4'h6, 4'h6, 5'd1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 6'h14, 4'hF, 4'hF, 5'd8},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'h26, 4'hF, 4'h3, 5'd16},
        '{1'b0, 1'b0, 1'b0, 1'b0, 6'h2A, 4'hE, 4'h2, 5'd1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 6'h3F, 4'hF, 4'h3, 5'd16},
        '{1'b0, 1'b0, 1'b1, 1'b1, 6'h10, 4'hF, 4'h0, 5'd1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'h30, 4'h5, 4'h5, 5'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wide = 1'b1, cfg_mpx = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [255:0]  req_wdata = '0;
    logic          busy, done, rd_valid, cs_n, rd_n, rnw;
    logic [31:0]   rd_data;
    logic [AW-1:0] bus_addr;
    logic [3:0]    we_n;
    wire  [31:0]   dq;

    int n_tot = 0;
    int n_bad = 0;

    logic [7:0] mem    [64];
    logic [7:0] shadow [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    bytesel_sram_ctrl #(.AW(AW), .WAIT_CYC(WAIT)) uut (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_mpx(cfg_mpx),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_rnw(rnw), .bus_addr(bus_addr),
        .bus_we_n(we_n), .bus_dq(dq)
    );

    // byte-lane memory model: drives only lanes whose select is low
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign dq[8*g +: 8] = (!cs_n && !rd_n && !we_n[g])
                              ? mem[6'(bus_addr[5:0] + 6'(g))] : 8'hzz;
    end

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            for (int g = 0; g < 4; g++)
                if (!cs_n && !rnw && !we_n[g])
                    mem[6'(bus_addr[5:0] + 6'(g))] <= dq[8*g +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_line(input int v);
        logic [255:0] r;
        for (int i = 0; i < 32; i++) r[8*i +: 8] = 8'(v * 37 + i * 5 + 17);
        return r;
    endfunction

    function automatic logic [5:0] exp_addr(input vec_t t, input int b);
        logic [5:0] s;
        logic [4:0] o;
        s = t.wide ? {t.addr[5:2], 2'b00} : {t.addr[5:1], 1'b0};
        o = 5'(s[4:0] + 5'(b * (t.wide ? 4 : 2)));
        return {t.addr[5], o};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a, input logic [3:0] lanes);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = lanes[i] ? shadow[6'(a + 6'(i))] : 8'h00;
        return r;
    endfunction

    task automatic mem_cmp(input string req);
        int mism = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) mism++;
        chk(mism == 0, req, 32'(mism), 32'd0);
    endtask

    // one table entry; called at 2 time units after a rising edge
    task automatic run_vec(input int v);
        vec_t         t = VECS[v];
        logic [255:0] line = mk_line(v);
        logic [5:0]   prev = '0;
        string        stag;
        stag = t.mpx ? "R9" : (!t.wide ? "R6" : (t.wr ? "R2" : "R4"));
        cfg_wide  = t.wide;  cfg_mpx  = t.mpx;
        req_write = t.wr;    req_burst = t.burst;
        req_addr  = AW'(t.addr); req_be = t.be; req_wdata = line;
        req_valid = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
        for (int b = 0; b < int'(t.beats); b++) begin
            logic [5:0] ea = exp_addr(t, b);
            chk(!cs_n && busy, "R8 select held", {31'd0, cs_n}, 32'd0);
            chk(bus_addr[5:0] == ea, "R7 beat address", 32'(bus_addr), 32'(ea));
            chk(we_n == 4'hF, "R3 setup quiet", 32'(we_n), 32'hF);
            chk(rnw == !t.wr, "R2 direction", 32'(rnw), 32'(!t.wr));
            if (b > 0 && !t.wr)
                chk(rd_valid && (t.mpx || rd_data == exp_rd(prev, t.lanes)),
                    "R5 beat data", rd_data, exp_rd(prev, t.lanes));
            #5;
            chk(we_n == 4'hF, "R3 setup quiet late", 32'(we_n), 32'hF);
            for (int w = 0; w <= WAIT; w++) begin
                #5;
                if (w == 0) chk(we_n == 4'hF, "R3 falls late", 32'(we_n), 32'hF);
                chk(rd_n == t.wr, "R4 read strobe", 32'(rd_n), 32'(t.wr));
                #5;
                chk(we_n == ~t.lanes, stag, 32'(we_n), 32'(~t.lanes));
            end
            #5;
            prev = ea;
        end
        chk(cs_n && done && !busy, "R10 end", {30'd0, cs_n, done}, 32'd3);
        chk(we_n == 4'hF, "R3 released at rise", 32'(we_n), 32'hF);
        if (!t.wr)
            chk(rd_valid && (t.mpx || rd_data == exp_rd(prev, t.lanes)),
                t.wide ? "R5 last data" : "R6 narrow data", rd_data,
                exp_rd(prev, t.lanes));
        if (t.wr) begin
            if (t.burst) begin
                for (int i = 0; i < 32; i++) shadow[{t.addr[5], 5'(i)}] = line[8*i +: 8];
            end else begin
                for (int i = 0; i < 4; i++)
                    if (t.lanes[i]) shadow[6'(exp_addr(t, 0) + 6'(i))] = line[8*i +: 8];
            end
            mem_cmp(t.mpx ? "R9 write stored" : "R11 write stored");
        end
        @(posedge clk); #2;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        #2;
        chk(cs_n && rd_n && rnw && we_n == 4'hF, "R1 bus idle in reset",
            {25'd0, cs_n, rd_n, rnw, we_n}, 32'h7F);
        chk(!busy && !done && !rd_valid, "R1 status in reset",
            {29'd0, busy, done, rd_valid}, 32'd0);
        rst = 1'b0;
        @(posedge clk); #2;
        chk(cs_n && rd_n && rnw && we_n == 4'hF && !busy, "R1 idle after reset",
            {24'd0, busy, cs_n, rd_n, rnw, we_n}, 32'h7F);
        mem_cmp("R1 memory untouched");

        for (int v = 0; v < NV; v++) run_vec(v);

        // R8: request held during a wrapped line read must not be taken
        begin
            int  cyc = 0;
            bit  held = 1'b1;
            cfg_wide = 1'b1; cfg_mpx = 1'b0;
            req_write = 1'b0; req_burst = 1'b1; req_addr = AW'(6'h24);
            req_be = 4'hF; req_valid = 1'b1;
            @(posedge clk); #2;
            req_write = 1'b1; req_burst = 1'b0; req_addr = AW'(6'h00);
            req_wdata = {256{1'b1}};
            while (!done && cyc < 100) begin
                if (cs_n || !rnw || bus_addr[5] != 1'b1) held = 1'b0;
                cyc++;
                @(posedge clk); #2;
            end
            req_valid = 1'b0;
            chk(held, "R8 bus held for line", {31'd0, held}, 32'd1);
            chk(cyc == 8 * (WAIT + 2), "R8 line length", 32'(cyc),
                32'(8 * (WAIT + 2)));
            @(posedge clk); #2;
            chk(!busy && cs_n, "R8 extra request ignored", {31'd0, busy}, 32'd0);
            mem_cmp("R8 no stray write");
        end

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule